// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

A clocked controller that carries out single-word reads and writes on an external asynchronous static RAM. The host raises `req_i` with a direction bit, an address, a 16-bit word and a per-byte mask. It holds them until the controller returns a one-cycle `ack_o`. The controller captures the request when it accepts it. It then drives the RAM's two chip selects (one active low, one active high), output enable, write enable and the two active-low byte enables. It also drives the data bus, with a drive-enable flag for the pad.

Each phase of a transaction lasts a fixed number of clock cycles, and each of those counts is a parameter. The default counts suit a 10 ns clock and the fastest speed grade of a 55 ns part. A write has an address phase, a write-strobe pulse and a hold phase. It ends on the rising edge of write enable while the selects are still active. A read has an access phase and then a turnaround phase, so the RAM has released the bus before the controller can drive it again. Address and byte enables stay stable while the part is selected.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it rises until a request is accepted, the outputs are: `mem_sel_n_o`=1, `mem_sel_o`=0, `mem_oe_n_o`=1, `mem_we_n_o`=1, `mem_be_n_o`=2'b11, `mem_dq_oe_o`=0 and `ack_o`=0.
- R2: For a write with a nonzero mask, the selects and byte enables go active `ADDR_CYC` cycles before `mem_we_n_o` falls. `mem_we_n_o` then stays low for max(`WP_CYC`,`DS_CYC`) cycles. The selects stay active for `HOLD_CYC` cycles after it rises. `ack_o` is high in the next cycle. With the default counts, `ack_o` is seen 7 cycles after the edge that accepts the request.
- R3: During a write, `mem_dq_oe_o` is high and `mem_dq_o` carries the accepted word in every cycle from the start of the address phase to the end of the hold phase. Write enable is low only while the selects and the data drive are active.
- R4: While the part is selected, `mem_addr_o` and `mem_be_n_o` do not change. The two selects always switch together (`mem_sel_o` = !`mem_sel_n_o`).
- R5: For a read with a nonzero mask, `mem_oe_n_o` is low together with the selects for `RD_CYC` cycles. Write enable stays high and the data drive stays off during that time. The bus is sampled on the edge that ends the access. With the default counts, `ack_o` is seen 9 cycles after the accepting edge.
- R6: Mask bit 0 drives `mem_be_n_o[0]` low and selects data bits [7:0]. Mask bit 1 drives `mem_be_n_o[1]` low and selects bits [15:8]. A byte written with its mask bit clear keeps its old value. A byte read with its mask bit clear returns zero in `rdata_o`.
- R7: `mem_dq_oe_o` is never high while `mem_oe_n_o` is low. After a read, output enable and the selects stay inactive for `TURN_CYC` cycles before `ack_o`. So the data drive never rises until output enable has been high for at least `TURN_CYC` cycles.
- R8: `ack_o` is high for exactly one cycle per request. `rdata_o` holds the last word read until the next read captures a new one.
- R9: A request with an all-zero mask is acknowledged in the cycle after the accepting edge. No select, enable or data-drive activity occurs.
- R10: A request is accepted only in the idle state. Address, data and mask are taken at that edge, so later changes on the host inputs have no effect on the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, held until acknowledged |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write word |
| mask_i | input | DW/8 | Byte mask, bit set = byte taking part |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Last read word |
| mem_addr_o | output | AW | RAM address |
| mem_sel_n_o | output | 1 | RAM select, active low |
| mem_sel_o | output | 1 | RAM select, active high |
| mem_oe_n_o | output | 1 | RAM output enable, active low |
| mem_we_n_o | output | 1 | RAM write enable, active low |
| mem_be_n_o | output | DW/8 | RAM byte enables, active low |
| mem_dq_o | output | DW | Data toward the RAM |
| mem_dq_oe_o | output | 1 | Pad drive enable for `mem_dq_o` |
| mem_dq_i | input | DW | Data from the RAM |

## Verification
The bench drives the controller with the following request patterns:
- Full-word writes and reads. These separate correct strobe timing from plain data movement.
- Writes and reads on a single byte lane, for each lane. These expose a swapped or inverted byte-enable mapping. The bench's RAM model returns a filler byte on disabled lanes, so a missing zero-fill on reads also shows up.
- A zero-mask write placed between a read and a later readback. This shows whether any strobe leaked.
- Reads followed at once by writes. These test the bus turnaround.
- An access at the highest modelled address.
- Host address and data inverted right after acceptance. Every readback then shows whether the controller used the values it captured or the live inputs.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_ADDR,
    ST_W_PULSE,
    ST_W_HOLD,
    ST_R_ACCESS,
    ST_R_TURN,
    ST_ACK
  } state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_req_regs.sv
module sram_req_regs #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NB-1:0] mask_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [NB-1:0] mask_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      mask_o  <= '0;
    end else if (load_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      mask_o  <= mask_i;
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW = 16,
  parameter int NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [NB-1:0] lane_en_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o
);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    rdata_o[b*8 +: 8] <= '0;
      else if (cap_i) rdata_o[b*8 +: 8] <= lane_en_i[b] ? dq_i[b*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int ADDR_CYC = 1,
  parameter int WP_CYC   = 4,
  parameter int DS_CYC   = 3,
  parameter int HOLD_CYC = 1,
  parameter int RD_CYC   = 6,
  parameter int TURN_CYC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW/8-1:0] mask_i,
  output logic            ack_o,
  output logic [DW-1:0]   rdata_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_sel_n_o,
  output logic            mem_sel_o,
  output logic            mem_oe_n_o,
  output logic            mem_we_n_o,
  output logic [DW/8-1:0] mem_be_n_o,
  output logic [DW-1:0]   mem_dq_o,
  output logic            mem_dq_oe_o,
  input  logic [DW-1:0]   mem_dq_i
);

  localparam int NB        = DW / 8;
  localparam int PULSE_CYC = max2(WP_CYC, DS_CYC);
  localparam int MAX_CYC   = max2(max2(ADDR_CYC, PULSE_CYC),
                                  max2(max2(HOLD_CYC, RD_CYC), TURN_CYC));
  localparam int CW        = max2($clog2(MAX_CYC + 1), 1);

  state_e        state_q, state_d;
  logic          accept, done, load, cap;
  logic [CW-1:0] load_val;
  logic [NB-1:0] mask_q, mask_nx;
  logic          sel_act_d;

  assign accept = (state_q == ST_IDLE) && req_i;

  sram_req_regs #(.AW(AW), .DW(DW), .NB(NB)) u_req (
    .clk_i, .rst_ni,
    .load_i  (accept),
    .addr_i, .wdata_i, .mask_i,
    .addr_o  (mem_addr_o),
    .wdata_o (mem_dq_o),
    .mask_o  (mask_q)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (mask_i == '0) state_d = ST_ACK;
          else if (we_i)    state_d = ST_W_ADDR;
          else              state_d = ST_R_ACCESS;
        end
      end
      ST_W_ADDR:   if (done) state_d = ST_W_PULSE;
      ST_W_PULSE:  if (done) state_d = ST_W_HOLD;
      ST_W_HOLD:   if (done) state_d = ST_ACK;
      ST_R_ACCESS: if (done) state_d = ST_R_TURN;
      ST_R_TURN:   if (done) state_d = ST_ACK;
      ST_ACK:      state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // phase length for the state being entered
  always_comb begin
    unique case (state_d)
      ST_W_ADDR:   load_val = CW'(ADDR_CYC - 1);
      ST_W_PULSE:  load_val = CW'(PULSE_CYC - 1);
      ST_W_HOLD:   load_val = CW'(HOLD_CYC - 1);
      ST_R_ACCESS: load_val = CW'(RD_CYC - 1);
      ST_R_TURN:   load_val = CW'(TURN_CYC - 1);
      default:     load_val = '0;
    endcase
  end

  assign load = (state_d != state_q);

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i, .rst_ni,
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // strobes registered from the next state: glitch-free pins
  assign sel_act_d = (state_d == ST_W_ADDR) || (state_d == ST_W_PULSE) ||
                     (state_d == ST_W_HOLD) || (state_d == ST_R_ACCESS);
  assign mask_nx   = accept ? mask_i : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_sel_n_o <= 1'b1;
      mem_sel_o   <= 1'b0;
      mem_oe_n_o  <= 1'b1;
      mem_we_n_o  <= 1'b1;
      mem_be_n_o  <= '1;
      mem_dq_oe_o <= 1'b0;
      ack_o       <= 1'b0;
    end else begin
      mem_sel_n_o <= !sel_act_d;
      mem_sel_o   <= sel_act_d;
      mem_oe_n_o  <= (state_d != ST_R_ACCESS);
      mem_we_n_o  <= (state_d != ST_W_PULSE);
      mem_be_n_o  <= sel_act_d ? ~mask_nx : '1;
      mem_dq_oe_o <= (state_d == ST_W_ADDR) || (state_d == ST_W_PULSE) ||
                     (state_d == ST_W_HOLD);
      ack_o       <= (state_d == ST_ACK);
    end
  end

  assign cap = (state_q == ST_R_ACCESS) && done;

  sram_rd_capture #(.DW(DW), .NB(NB)) u_cap (
    .clk_i, .rst_ni,
    .cap_i     (cap),
    .lane_en_i (mask_q),
    .dq_i      (mem_dq_i),
    .rdata_o
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int WP_CYC   = 4,
  parameter int TURN_CYC = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ack_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic            mem_sel_n_o,
  input logic            mem_sel_o,
  input logic            mem_oe_n_o,
  input logic            mem_we_n_o,
  input logic [DW/8-1:0] mem_be_n_o,
  input logic            mem_dq_oe_o
);

  localparam int CMAX = ((WP_CYC > TURN_CYC) ? WP_CYC : TURN_CYC) + 1;
  localparam int CNTW = $clog2(CMAX + 1);

  logic [CNTW-1:0] we_lo_cnt, oe_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= CNTW'(CMAX);
    end else begin
      if (mem_we_n_o)                   we_lo_cnt <= '0;
      else if (we_lo_cnt != CNTW'(CMAX)) we_lo_cnt <= we_lo_cnt + 1'b1;
      if (!mem_oe_n_o)                  oe_hi_cnt <= '0;
      else if (oe_hi_cnt != CNTW'(CMAX)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end
  end

  assert_pulse_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_lo_cnt >= CNTW'(WP_CYC)));

  assert_we_in_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (!mem_sel_n_o && mem_sel_o && mem_dq_oe_o));

  assert_addr_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_sel_n_o && $past(!mem_sel_n_o)) |-> ($stable(mem_addr_o) && $stable(mem_be_n_o)));

  assert_sel_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sel_o != mem_sel_n_o);

  assert_oe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (mem_we_n_o && !mem_sel_n_o));

  assert_no_contention_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);

  assert_turnaround_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (oe_hi_cnt >= CNTW'(TURN_CYC)));

  assert_ack_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .AW(AW), .DW(DW), .WP_CYC(WP_CYC), .TURN_CYC(TURN_CYC)
) chk_i (
  .clk_i, .rst_ni, .ack_o, .mem_addr_o, .mem_sel_n_o, .mem_sel_o,
  .mem_oe_n_o, .mem_we_n_o, .mem_be_n_o, .mem_dq_oe_o
);

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;

  localparam int AW    = 18;
  localparam int DW    = 16;
  localparam int W_LAT = 1 + 4 + 1 + 1;  // addr + pulse + hold + ack
  localparam int R_LAT = 6 + 2 + 1;      // access + turn + ack
  localparam int NV    = 12;

  // {we, mask[1:0], addr[5:0], wdata[15:0], expected read[15:0]}
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 2'b11, 6'h01, 16'hA5C3, 16'h0000},
    {1'b1, 2'b11, 6'h02, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 6'h01, 16'h0000, 16'hA5C3},
    {1'b1, 2'b01, 6'h01, 16'hFF77, 16'h0000},
    {1'b0, 2'b11, 6'h01, 16'h0000, 16'hA577},
    {1'b1, 2'b10, 6'h02, 16'h9A00, 16'h0000},
    {1'b0, 2'b10, 6'h02, 16'h0000, 16'h9A00},
    {1'b0, 2'b01, 6'h02, 16'h0000, 16'h0034},
    {1'b1, 2'b00, 6'h02, 16'hFFFF, 16'h0000},
    {1'b0, 2'b11, 6'h02, 16'h0000, 16'h9A34},
    {1'b1, 2'b11, 6'h3F, 16'h0F0F, 16'h0000},
    {1'b0, 2'b11, 6'h3F, 16'h0000, 16'h0F0F}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0]    mask = '0;
  logic          ack;
  logic [DW-1:0] rdata, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;
  logic          sel_n, sel, oe_n, we_n, dq_oe;
  logic [1:0]    be_n;

  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  sram_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .mask_i(mask), .ack_o(ack), .rdata_o(rdata),
    .mem_addr_o(mem_addr), .mem_sel_n_o(sel_n), .mem_sel_o(sel),
    .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_be_n_o(be_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(mem_dq_i)
  );

  // RAM model, 64 words
  logic [15:0] mem [64];
  initial for (int i = 0; i < 64; i++) mem[i] = 16'h0000;

  always @(posedge we_n) begin
    if (sel_n === 1'b0 && sel === 1'b1) begin
      if (!be_n[0]) mem[mem_addr[5:0]][7:0]  = mem_dq_o[7:0];
      if (!be_n[1]) mem[mem_addr[5:0]][15:8] = mem_dq_o[15:8];
    end
  end

  always_comb begin
    mem_dq_i = 16'hEEEE;
    if (!sel_n && sel && !oe_n && we_n) begin
      if (!be_n[0]) mem_dq_i[7:0]  = mem[mem_addr[5:0]][7:0];
      if (!be_n[1]) mem_dq_i[15:8] = mem[mem_addr[5:0]][15:8];
    end
  end

  // pin monitor
  int we_run = 0, last_we_len = 0, oe_run = 0, last_oe_len = 0;
  int sel_run = 0, last_pre = 0, sel_cycles = 0, oe_hi_run = 100;
  int bad_contention = 0, bad_dq = 0, bad_addr = 0, bad_turn = 0;
  logic          prev_dq_oe = 1'b0, prev_sel = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [15:0]   cur_wdata = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n && we_run == 0) last_pre = sel_run;
      if (!we_n) we_run++;
      else if (we_run != 0) begin last_we_len = we_run; we_run = 0; end
      if (!oe_n) oe_run++;
      else if (oe_run != 0) begin last_oe_len = oe_run; oe_run = 0; end
      if (!sel_n) begin sel_run++; sel_cycles++; end else sel_run = 0;
      if (dq_oe && !oe_n) bad_contention++;
      if (!we_n && (!dq_oe || mem_dq_o !== cur_wdata)) bad_dq++;
      if (!sel_n && prev_sel && mem_addr !== prev_addr) bad_addr++;
      if (dq_oe && !prev_dq_oe && oe_hi_run < 2) bad_turn++;
      if (!oe_n) oe_hi_run = 0; else oe_hi_run++;
      prev_dq_oe = dq_oe;
      prev_sel   = !sel_n;
      prev_addr  = mem_addr;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic w, input logic [1:0] m, input logic [5:0] a,
                        input logic [15:0] d, output int lat, output logic [15:0] rd);
    @(negedge clk);
    req = 1'b1; we = w; mask = m; addr = {12'h000, a}; wdata = d; cur_wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin addr = ~addr; wdata = ~wdata; mask = ~mask; we = ~we; end  // R10
    end while (!ack && lat < 50);
    rd  = rdata;
    req = 1'b0;
    @(negedge clk);
    chk("R8 ack single cycle", {31'h0, ack}, 32'h0);
  endtask

  initial begin
    int          lat;
    logic [15:0] rd;
    int          sel_before;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {23'h0, sel_n, sel, oe_n, we_n, be_n, dq_oe, ack},
        {23'h0, 9'b1_0_1_1_11_0_0});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {23'h0, sel_n, sel, oe_n, we_n, be_n, dq_oe, ack},
        {23'h0, 9'b1_0_1_1_11_0_0});

    for (int i = 0; i < NV; i++) begin
      sel_before = sel_cycles;
      do_req(VEC[i][40], VEC[i][39:38], VEC[i][37:32], VEC[i][31:16], lat, rd);
      if (VEC[i][39:38] == 2'b00) begin
        chk("R9 zero mask latency", lat, 1);
        chk("R9 zero mask no strobes", sel_cycles - sel_before, 0);
      end else if (VEC[i][40]) begin
        chk("R2 write latency", lat, W_LAT);
        chk("R2 write pulse width", last_we_len, 4);
        chk("R2 address phase length", last_pre, 1);
      end else begin
        chk("R5 read latency", lat, R_LAT);
        chk("R5 output enable width", last_oe_len, 6);
        chk("R6 R10 read data", {16'h0, rd}, {16'h0, VEC[i][15:0]});
      end
      if (i == 10) chk("R8 rdata held across write", {16'h0, rdata}, 32'h9A34);
    end

    chk("R3 write data driven under strobe", bad_dq, 0);
    chk("R4 address stable while selected", bad_addr, 0);
    chk("R7 no bus contention", bad_contention, 0);
    chk("R7 turnaround before drive", bad_turn, 0);
    chk("R1 idle at end", {23'h0, sel_n, sel, oe_n, we_n, be_n, dq_oe, ack},
        {23'h0, 9'b1_0_1_1_11_0_0});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule